// File: doc/BRIEF.md
# DAC Data Register Update Controller

This block is the register front end of a 12-bit voltage-output converter. A host drives a byte-wide bus to write and read three registers: a high data byte, a low data byte and a control byte. The control byte turns the converter on or off, picks the event that moves new data to the converter, and picks how the two data bytes are aligned into the 12-bit code.

Writes to the data bytes only change two staging registers. The 12-bit output code changes when the chosen update event occurs. That event is either a write to the high byte or a one-cycle overflow strobe from one of three external timers. At that moment the staging bytes are packed using the alignment format in force and stored in the output holding register. Reads return the stored bytes exactly as they were written.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset the low byte, high byte and control byte all read 0x00, `dac_en` is 0 and `dac_code` is 0x000.
- R2: The low byte sits at address 0xD2, the high byte at 0xD3 and the control byte at 0xD4. A read while `bus_rd` is high returns the stored byte unchanged, with no realignment.
- R3: Control bits 6 and 5 are unused. They always read 0, and writing 1 to them has no effect.
- R4: `dac_en` follows control bit 7: 1 means the converter is active and 0 means it is shut down.
- R5: With control bits 4:3 = 00, a high-byte write loads `dac_code` at that same clock edge. The code is built from the newly written high byte and the current low byte.
- R6: With trigger 00, a low-byte write or any timer strobe leaves `dac_code` unchanged.
- R7: With trigger 01, 10 or 11, data writes leave `dac_code` unchanged. The code is loaded when the matching strobe is high at a clock edge: 01 selects `tmr_ovf_a`, 10 selects `tmr_ovf_b` and 11 selects `tmr_ovf_c`.
- R8: Strobes from the two timers that are not selected leave `dac_code` unchanged.
- R9: Control bits 2:0 give the format F. For F = 0 to 3 the code is bits [F+11:F] of the 16-bit value {high, low}. For example, F=1 gives code[11:7]=high[4:0] and code[6:0]=low[7:1].
- R10: Any format of the form 1xx gives code[11:4]=high[7:0] and code[3:0]=low[7:4].
- R11: The format is applied only at the update moment. Changing the format bits does not alter a code that has already been latched.
- R12: Reads of any other address return 0x00, and writes to any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not reading |
| tmr_ovf_a | input | 1 | Overflow strobe selected by trigger 01 |
| tmr_ovf_b | input | 1 | Overflow strobe selected by trigger 10 |
| tmr_ovf_c | input | 1 | Overflow strobe selected by trigger 11 |
| dac_en | output | 1 | Converter enable |
| dac_code | output | 12 | Latched converter code |

## Verification
The assertions take for granted that the timer strobes and bus writes are synchronous to `clk` and last one cycle each. They also assume that a bus write and a read are never requested in the same cycle. The stimulus drives every strobe and write for exactly one cycle, changing them at the falling edge, and never drives reads and writes together. Strobes on unselected timers are driven on purpose to exercise R8. The selected strobe is never combined with a data write in the same cycle.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 12;
    localparam int FMT_W  = 3;

    // Update trigger selection; encoding is fixed by control bits 4:3
    typedef enum logic [1:0] {
        TRIG_HI_WRITE = 2'b00,
        TRIG_OVF_A    = 2'b01,
        TRIG_OVF_B    = 2'b10,
        TRIG_OVF_C    = 2'b11
    } trig_e;

    typedef struct packed {
        logic             en;
        logic [1:0]       spare;
        trig_e            trig;
        logic [FMT_W-1:0] fmt;
    } ctrl_t;

endpackage

// File: rtl/dac_regfile.sv
module dac_regfile
    import dac_upd_pkg::*;
#(
    parameter int              ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO   = 8'hD2,
    parameter logic [ADDR_W-1:0] ADDR_HI   = 8'hD3,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hD4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output logic [BYTE_W-1:0] hi_q,
    output logic [BYTE_W-1:0] lo_q,
    output logic              en_o,
    output trig_e             trig_o,
    output logic [FMT_W-1:0]  fmt_o,
    output logic              hi_wr_stb
);

    ctrl_t ctrl_q;

    logic sel_lo, sel_hi, sel_ctrl;
    assign sel_lo   = (addr == ADDR_LO);
    assign sel_hi   = (addr == ADDR_HI);
    assign sel_ctrl = (addr == ADDR_CTRL);

    assign hi_wr_stb = wr && sel_hi;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            ctrl_q <= '0;
        end else if (wr) begin
            if (sel_lo) lo_q <= wdata;
            if (sel_hi) hi_q <= wdata;
            if (sel_ctrl) begin
                ctrl_q.en    <= wdata[7];
                ctrl_q.spare <= 2'b00;
                ctrl_q.trig  <= trig_e'(wdata[4:3]);
                ctrl_q.fmt   <= wdata[FMT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (1'b1)
                sel_lo:   rdata = lo_q;
                sel_hi:   rdata = hi_q;
                sel_ctrl: rdata = ctrl_q;
                default:  rdata = '0;
            endcase
        end
    end

    assign en_o   = ctrl_q.en;
    assign trig_o = ctrl_q.trig;
    assign fmt_o  = ctrl_q.fmt;

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel_ctrl) |-> (rdata[6:5] == 2'b00)); // R3

    AST_EN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel_ctrl) |=> (en_o == $past(wdata[7]))); // R4

endmodule

// File: rtl/dac_trig_sel.sv
module dac_trig_sel
    import dac_upd_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  trig_e trig,
    input  logic  hi_wr_stb,
    input  logic  ovf_a,
    input  logic  ovf_b,
    input  logic  ovf_c,
    output logic  load
);

    always_comb begin
        load = 1'b0;
        unique case (trig)
            TRIG_HI_WRITE: load = hi_wr_stb;
            TRIG_OVF_A:    load = ovf_a;
            TRIG_OVF_B:    load = ovf_b;
            TRIG_OVF_C:    load = ovf_c;
            default:       load = 1'b0;
        endcase
    end

    AST_HIWR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (trig == TRIG_HI_WRITE && hi_wr_stb) |-> load); // R5

    AST_TIMER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (trig != TRIG_HI_WRITE && load) |-> (ovf_a || ovf_b || ovf_c)); // R8

endmodule

// File: rtl/dac_packer.sv
module dac_packer
    import dac_upd_pkg::*;
#(
    parameter int B_W = BYTE_W,
    parameter int C_W = CODE_W,
    parameter int F_W = FMT_W
) (
    input  logic [B_W-1:0] hi,
    input  logic [B_W-1:0] lo,
    input  logic [F_W-1:0] fmt,
    output logic [C_W-1:0] code
);

    localparam int MAX_SHIFT = 2*B_W - C_W;
    localparam int NUM_FMT   = MAX_SHIFT + 1;

    logic [2*B_W-1:0] joined;
    logic [C_W-1:0]   cand [NUM_FMT];

    assign joined = {hi, lo};

    // One alignment variant per shift amount
    for (genvar k = 0; k < NUM_FMT; k++) begin : g_align
        assign cand[k] = joined[k +: C_W];
    end

    always_comb begin
        code = cand[MAX_SHIFT];
        for (int k = 0; k < MAX_SHIFT; k++) begin
            if (int'(fmt) == k) code = cand[k];
        end
    end

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              tmr_ovf_a,
    input  logic              tmr_ovf_b,
    input  logic              tmr_ovf_c,
    output logic              dac_en,
    output logic [CODE_W-1:0] dac_code
);

    logic [BYTE_W-1:0] hi_q, lo_q, pack_hi;
    logic [FMT_W-1:0]  fmt;
    trig_e             trig;
    logic              hi_wr_stb, load;
    logic [CODE_W-1:0] packed_code;

    dac_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .hi_q      (hi_q),
        .lo_q      (lo_q),
        .en_o      (dac_en),
        .trig_o    (trig),
        .fmt_o     (fmt),
        .hi_wr_stb (hi_wr_stb)
    );

    dac_trig_sel u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .hi_wr_stb (hi_wr_stb),
        .ovf_a     (tmr_ovf_a),
        .ovf_b     (tmr_ovf_b),
        .ovf_c     (tmr_ovf_c),
        .load      (load)
    );

    // In high-write mode the fresh byte is packed in the same cycle
    assign pack_hi = (trig == TRIG_HI_WRITE && hi_wr_stb) ? bus_wdata : hi_q;

    dac_packer u_pack (
        .hi   (pack_hi),
        .lo   (lo_q),
        .fmt  (fmt),
        .code (packed_code)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dac_code <= '0;
        else if (load) dac_code <= packed_code;
    end

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dac_code)); // R7

    AST_FMT_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'hD4 && !load) |=> $stable(dac_code)); // R11

endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0, bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        tmr_ovf_a = 1'b0, tmr_ovf_b = 1'b0, tmr_ovf_c = 1'b0;
    logic        dac_en;
    logic [11:0] dac_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    dac_update_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_ovf_a(tmr_ovf_a), .tmr_ovf_b(tmr_ovf_b), .tmr_ovf_c(tmr_ovf_c),
        .dac_en(dac_en), .dac_code(dac_code)
    );

    localparam logic [7:0] A_LO = 8'hD2, A_HI = 8'hD3, A_CT = 8'hD4;

    // {fmt[2:0], hi[7:0], lo[7:0], expected code[11:0]}, trigger 00
    localparam int NVEC = 10;
    localparam logic [30:0] VEC [NVEC] = '{
        {3'd0, 8'hA5, 8'h3C, 12'h53C},
        {3'd1, 8'hA5, 8'h3C, 12'h29E},
        {3'd2, 8'hA5, 8'h3C, 12'h94F},
        {3'd3, 8'hA5, 8'h3C, 12'h4A7},
        {3'd4, 8'hA5, 8'h3C, 12'hA53},
        {3'd7, 8'hA5, 8'h3C, 12'hA53},
        {3'd0, 8'hFF, 8'h01, 12'hF01},
        {3'd2, 8'hFF, 8'h01, 12'hFC0},
        {3'd5, 8'hFF, 8'h01, 12'hFF0},
        {3'd3, 8'h00, 8'hFF, 12'h01F}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        check(req, 32'(bus_rdata), 32'(exp));
        bus_rd = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        tmr_ovf_a = (which == 0); tmr_ovf_b = (which == 1); tmr_ovf_c = (which == 2);
        @(negedge clk);
        tmr_ovf_a = 1'b0; tmr_ovf_b = 1'b0; tmr_ovf_c = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 code", 32'(dac_code), 0);
        check("R1 en", 32'(dac_en), 0);
        rd_chk("R1 lo", A_LO, 8'h00);
        rd_chk("R1 hi", A_HI, 8'h00);
        rd_chk("R1 ctrl", A_CT, 8'h00);

        // R2 readback
        wr(A_LO, 8'h5A);
        wr(A_HI, 8'hC3);
        rd_chk("R2 lo", A_LO, 8'h5A);
        rd_chk("R2 hi", A_HI, 8'hC3);

        // R3 spare bits, R4 enable
        wr(A_CT, 8'hFF);
        rd_chk("R3 ctrl", A_CT, 8'h9F);
        check("R4 en on", 32'(dac_en), 1);
        wr(A_CT, 8'h00);
        check("R4 en off", 32'(dac_en), 0);

        // R5 / R9 / R10 vector walk
        for (int i = 0; i < NVEC; i++) begin
            logic [30:0] v;
            v = VEC[i];
            wr(A_CT, {1'b1, 2'b00, 2'b00, v[30:28]});
            wr(A_LO, v[19:12]);
            wr(A_HI, v[27:20]);
            check(v[30] ? "R10 format 1xx" : "R5 R9 format", 32'(dac_code), 32'(v[11:0]));
        end

        // R11 format change keeps latched code
        wr(A_CT, 8'h80);
        check("R11 fmt change", 32'(dac_code), 32'h01F);
        // R6 low write and strobes ignored in trigger 00
        wr(A_LO, 8'h77);
        check("R6 lo write", 32'(dac_code), 32'h01F);
        pulse(0); pulse(2);
        check("R6 strobe", 32'(dac_code), 32'h01F);

        // R7 trigger 01
        wr(A_CT, 8'h88);
        wr(A_HI, 8'h02);
        check("R7 hi write held", 32'(dac_code), 32'h01F);
        pulse(0);
        check("R7 ovf_a load", 32'(dac_code), 32'h277);
        // R8 unselected strobes
        wr(A_HI, 8'h03);
        pulse(1); pulse(2);
        check("R8 unselected", 32'(dac_code), 32'h277);
        pulse(0);
        check("R7 ovf_a load2", 32'(dac_code), 32'h377);
        // R11 format applied at update
        wr(A_CT, 8'h8C);
        check("R11 held", 32'(dac_code), 32'h377);
        pulse(0);
        check("R11 new fmt", 32'(dac_code), 32'h037);
        // R7 trigger 10 and 11
        wr(A_CT, 8'h90);
        pulse(0);
        check("R8 a in mode 10", 32'(dac_code), 32'h037);
        pulse(1);
        check("R7 ovf_b load", 32'(dac_code), 32'h377);
        wr(A_CT, 8'h98);
        wr(A_LO, 8'h11);
        pulse(1);
        check("R8 b in mode 11", 32'(dac_code), 32'h377);
        pulse(2);
        check("R7 ovf_c load", 32'(dac_code), 32'h311);

        // R12 unmapped addresses
        rd_chk("R12 read", 8'hD5, 8'h00);
        wr(8'hD1, 8'hFF);
        rd_chk("R12 lo kept", A_LO, 8'h11);
        rd_chk("R12 hi kept", A_HI, 8'h03);
        rd_chk("R12 ctrl kept", A_CT, 8'h98);
        check("R12 code kept", 32'(dac_code), 32'h311);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule